// File: doc/BRIEF.md
# Floppy Sector Locate and Read

This block sits behind the read amplifier of a soft-sectored floppy drive. It takes one data bit per strobe from the drive and builds 8-bit disk codes from them. After a request with a track number, a sector number and a one-cycle start pulse, it scans the passing address headers for the requested sector. It then opens the data field that follows the matching header. It turns each disk code of that field into a 6-bit value, presents the value on a strobed output, and keeps an XOR checksum up to date as the codes arrive.

The request ends with a one-cycle done pulse. At that pulse at most one of three flags is set: checksum mismatch, illegal code, or sector not found. An optional retry mode restarts the search on its own after a failed field, up to a set limit, so that a transient error never reaches the flags. With retry off, every error is reported. Rebuilding full bytes from the 6-bit values is done downstream.

Top module: `sector_seek_reader`

## Requirements
- R1: On each cycle with `rd_stb` high, `rd_bit` is shifted into an 8-bit register, most significant bit first. When bit 7 of the shifted value is 1, that value is one complete disk code and the register restarts from zero. Zero bits between codes are discarded. Bits may arrive on every cycle.
- R2: An address header starts with the three codes 0xD5 0xAA 0x96. Three byte pairs follow in this order: volume, track, sector. Each pair carries a value v as first code (v>>1)|0xAA and second code v|0xAA, and it is decoded as ((first<<1)|1) & second.
- R3: The header matches only when both the decoded track and the decoded sector equal the requested ones. After a match, the data field opens at the next 0xD5 0xAA 0xAD. An address prologue seen before that is handled as a new header.
- R4: A valid disk code has bit 7 set, has at least one pair of adjacent 1 bits among bits 6..0, and has at most one pair of adjacent 0 bits. Its 6-bit value is its rank among the 64 valid codes in ascending order, so 0x96 gives 0 and 0xFF gives 63.
- R5: Each of the DATA_LEN data codes produces one `nib_vld` pulse, with its value on `nib_val`, in disk order.
- R6: The code after the last data code is decoded and compared with the XOR of all DATA_LEN values. If they differ, `done` pulses with `sum_err` set. If they are equal, `done` pulses with no flag.
- R7: An invalid code anywhere in the data field or in the checksum position ends the request at once, with `done` and `code_err`.
- R8: If MAX_HDRS headers in a row fail to match, `done` pulses with `not_found` set. A match at header MAX_HDRS still succeeds.
- R9: With `retry_en` high, a checksum or illegal-code failure restarts the header search with the header count cleared, up to MAX_RETRY times, and only the next failure after that is reported. With `retry_en` low, the first failure is reported.
- R10: After reset, and in the cycle after `req_go`, all flags are clear. `busy` is low after reset and high after `req_go`.
- R11: `done` lasts one cycle, and `busy` is low while it is high. At most one flag is set at a time. Flags hold their value until the next `req_go`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_stb | input | 1 | A read bit is present this cycle |
| rd_bit | input | 1 | Read bit value |
| req_go | input | 1 | Start a sector request (one cycle) |
| req_track | input | 8 | Requested track |
| req_sector | input | 8 | Requested sector |
| retry_en | input | 1 | Enable automatic retry on data-field errors |
| nib_vld | output | 1 | Decoded 6-bit value valid |
| nib_val | output | 6 | Decoded 6-bit value |
| busy | output | 1 | Request in progress |
| done | output | 1 | Request finished (one-cycle pulse) |
| sum_err | output | 1 | Checksum mismatch |
| code_err | output | 1 | Illegal disk code in data field |
| not_found | output | 1 | Requested sector not seen within the header limit |

## Verification
The controller decodes one completed code, folds it into the checksum and, for the last code, compares it. In that same cycle the assembler may already be shifting in the first bit of the next code. The bench provokes this overlap by sending whole sectors with no idle cycle between bit strobes, and it mixes these runs with runs that have random gaps. Each run is judged by matching the decoded stream against the values that were encoded, and by the flag seen at `done`, including a corrupted checksum code placed right after the last data code.

// File: rtl/sf_pkg.sv
package sf_pkg;

  localparam int BYTE_W = 8;
  localparam int VAL_W  = 6;

  localparam logic [BYTE_W-1:0] MARK_A    = 8'hD5;
  localparam logic [BYTE_W-1:0] MARK_B    = 8'hAA;
  localparam logic [BYTE_W-1:0] MARK_ADDR = 8'h96;
  localparam logic [BYTE_W-1:0] MARK_DATA = 8'hAD;

  typedef enum logic [2:0] {
    S_IDLE, S_HUNT, S_HDR, S_DHUNT, S_DATA, S_SUM
  } seek_state_t;

  // A code is legal when bit 7 is set, some adjacent pair in 6..0 is 11,
  // and no more than one adjacent pair is 00.
  function automatic logic code_ok(input logic [BYTE_W-1:0] c);
    return c[7] && (|(c[5:0] & c[6:1])) &&
           ($countones(~c[6:0] & ~c[7:1]) <= 1);
  endfunction

  // {legal, rank among legal codes}
  function automatic logic [VAL_W:0] code_lookup(input logic [BYTE_W-1:0] c);
    int r;
    r = 0;
    for (int k = 128; k < 256; k++)
      if (k < int'(c) && code_ok(8'(k))) r++;
    return {code_ok(c) && (r < 64), r[VAL_W-1:0]};
  endfunction

endpackage

// File: rtl/sf_bit_shifter.sv
module sf_bit_shifter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         bit_stb,
  input  logic         bit_val,
  output logic         byte_stb,
  output logic [W-1:0] byte_q
);
  logic [W-1:0] sr;
  logic [W-1:0] nxt;

  assign nxt = {sr[W-2:0], bit_val};

  always_ff @(posedge clk) begin
    if (rst) begin
      sr       <= '0;
      byte_stb <= 1'b0;
      byte_q   <= '0;
    end else begin
      byte_stb <= 1'b0;
      if (bit_stb) begin
        if (nxt[W-1]) begin
          byte_stb <= 1'b1;
          byte_q   <= nxt;
          sr       <= '0;
        end else begin
          sr <= nxt;
        end
      end
    end
  end
endmodule

// File: rtl/sf_code_rom.sv
module sf_code_rom
  import sf_pkg::*;
(
  input  logic [BYTE_W-1:0] code,
  output logic              ok,
  output logic [VAL_W-1:0]  val
);
  localparam int DEPTH = 1 << BYTE_W;

  logic [VAL_W:0] rom [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_rom
    assign rom[g] = code_lookup(BYTE_W'(g));
  end

  assign {ok, val} = rom[code];
endmodule

// File: rtl/sf_seek_ctrl.sv
module sf_seek_ctrl
  import sf_pkg::*;
#(
  parameter int DATA_LEN  = 342,
  parameter int MAX_HDRS  = 32,
  parameter int MAX_RETRY = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_go,
  input  logic [BYTE_W-1:0] req_track,
  input  logic [BYTE_W-1:0] req_sector,
  input  logic              retry_en,
  input  logic              byte_stb,
  input  logic [BYTE_W-1:0] byte_q,
  input  logic              code_good,
  input  logic [VAL_W-1:0]  code_val,
  output logic              nib_vld,
  output logic [VAL_W-1:0]  nib_val,
  output logic              busy,
  output logic              done,
  output logic              sum_err,
  output logic              code_err,
  output logic              not_found
);
  localparam int CW = $clog2(DATA_LEN + 1);
  localparam int HW = $clog2(MAX_HDRS + 1);
  localparam int RW = $clog2(MAX_RETRY + 2);

  seek_state_t       st;
  logic [BYTE_W-1:0] hist1, hist0, first_q, trk_q, sec_q, hdr_val;
  logic [2:0]        hidx;
  logic              trk_ok;
  logic [HW-1:0]     hdr_q;
  logic [RW-1:0]     rt_q;
  logic [CW-1:0]     dcnt;
  logic [VAL_W-1:0]  xsum;
  logic              addr_hit, data_hit, bad_code, bad_sum, can_retry;

  always_comb begin
    addr_hit  = (hist1 == MARK_A) && (hist0 == MARK_B) && (byte_q == MARK_ADDR);
    data_hit  = (hist1 == MARK_A) && (hist0 == MARK_B) && (byte_q == MARK_DATA);
    hdr_val   = {first_q[BYTE_W-2:0], 1'b1} & byte_q;
    bad_code  = ((st == S_DATA) || (st == S_SUM)) && !code_good;
    bad_sum   = (st == S_SUM) && code_good && (code_val != xsum);
    can_retry = retry_en && (rt_q != RW'(MAX_RETRY));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_IDLE;
      {hist1, hist0, first_q, trk_q, sec_q} <= '0;
      hidx <= '0; trk_ok <= 1'b0; hdr_q <= '0; rt_q <= '0;
      dcnt <= '0; xsum <= '0;
      nib_vld <= 1'b0; nib_val <= '0; busy <= 1'b0; done <= 1'b0;
      sum_err <= 1'b0; code_err <= 1'b0; not_found <= 1'b0;
    end else begin
      nib_vld <= 1'b0;
      done    <= 1'b0;
      if (req_go) begin
        st <= S_HUNT;
        trk_q <= req_track; sec_q <= req_sector;
        hist1 <= '0; hist0 <= '0; hdr_q <= '0; rt_q <= '0;
        busy <= 1'b1;
        sum_err <= 1'b0; code_err <= 1'b0; not_found <= 1'b0;
      end else if (byte_stb && st != S_IDLE) begin
        hist1 <= hist0;
        hist0 <= byte_q;
        if (bad_code || bad_sum) begin
          if (can_retry) begin
            rt_q  <= rt_q + RW'(1);
            hdr_q <= '0;
            st    <= S_HUNT;
          end else begin
            st <= S_IDLE; busy <= 1'b0; done <= 1'b1;
            code_err <= bad_code;
            sum_err  <= bad_sum;
          end
        end else begin
          unique case (st)
            S_HUNT: if (addr_hit) begin st <= S_HDR; hidx <= '0; end
            S_HDR: begin
              hidx    <= hidx + 3'd1;
              first_q <= byte_q;
              if (hidx == 3'd3) trk_ok <= (hdr_val == trk_q);
              if (hidx == 3'd5) begin
                hdr_q <= hdr_q + HW'(1);
                if (trk_ok && hdr_val == sec_q) st <= S_DHUNT;
                else if (hdr_q == HW'(MAX_HDRS - 1)) begin
                  st <= S_IDLE; busy <= 1'b0; done <= 1'b1; not_found <= 1'b1;
                end else st <= S_HUNT;
              end
            end
            S_DHUNT: begin
              if (data_hit) begin
                st <= S_DATA; dcnt <= '0; xsum <= '0;
              end else if (addr_hit) begin
                st <= S_HDR; hidx <= '0;
              end
            end
            S_DATA: begin
              nib_vld <= 1'b1;
              nib_val <= code_val;
              xsum    <= xsum ^ code_val;
              dcnt    <= dcnt + CW'(1);
              if (dcnt == CW'(DATA_LEN - 1)) st <= S_SUM;
            end
            S_SUM: begin st <= S_IDLE; busy <= 1'b0; done <= 1'b1; end
            default: st <= S_IDLE;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/sector_seek_reader.sv
module sector_seek_reader
  import sf_pkg::*;
#(
  parameter int DATA_LEN  = 342,
  parameter int MAX_HDRS  = 32,
  parameter int MAX_RETRY = 3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       rd_stb,
  input  logic       rd_bit,
  input  logic       req_go,
  input  logic [7:0] req_track,
  input  logic [7:0] req_sector,
  input  logic       retry_en,
  output logic       nib_vld,
  output logic [5:0] nib_val,
  output logic       busy,
  output logic       done,
  output logic       sum_err,
  output logic       code_err,
  output logic       not_found
);
  logic              byte_stb;
  logic [BYTE_W-1:0] byte_q;
  logic              code_good;
  logic [VAL_W-1:0]  code_val;

  sf_bit_shifter #(.W(BYTE_W)) u_shift (
    .clk(clk), .rst(rst), .bit_stb(rd_stb), .bit_val(rd_bit),
    .byte_stb(byte_stb), .byte_q(byte_q)
  );

  sf_code_rom u_rom (.code(byte_q), .ok(code_good), .val(code_val));

  sf_seek_ctrl #(
    .DATA_LEN(DATA_LEN), .MAX_HDRS(MAX_HDRS), .MAX_RETRY(MAX_RETRY)
  ) u_ctrl (
    .clk(clk), .rst(rst), .req_go(req_go), .req_track(req_track),
    .req_sector(req_sector), .retry_en(retry_en),
    .byte_stb(byte_stb), .byte_q(byte_q),
    .code_good(code_good), .code_val(code_val),
    .nib_vld(nib_vld), .nib_val(nib_val), .busy(busy), .done(done),
    .sum_err(sum_err), .code_err(code_err), .not_found(not_found)
  );
endmodule

// File: rtl/sf_checker.sv
module sf_checker (
  input logic clk,
  input logic rst,
  input logic req_go,
  input logic nib_vld,
  input logic busy,
  input logic done,
  input logic sum_err,
  input logic code_err,
  input logic not_found
);
  // R10
  go_busy_chk: assert property (@(posedge clk) disable iff (rst)
    req_go |=> busy);
  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R11
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
  // R11
  flag_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({sum_err, code_err, not_found}));
  // R11
  flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!done && !$past(req_go)) |-> $stable({sum_err, code_err, not_found}));
  // R5
  nib_busy_chk: assert property (@(posedge clk) disable iff (rst)
    nib_vld |-> (busy && !done));
  // R8
  nf_done_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(not_found) |-> done);
endmodule

bind sector_seek_reader sf_checker u_sf_checker (
  .clk(clk), .rst(rst), .req_go(req_go), .nib_vld(nib_vld), .busy(busy),
  .done(done), .sum_err(sum_err), .code_err(code_err), .not_found(not_found)
);

// File: tb/test_sector_seek_reader.sv
`timescale 1ns/1ps
module test_sector_seek_reader;
  localparam int DLEN = 24;
  localparam int MAXH = 4;
  localparam int MAXR = 1;

  logic clk = 1'b0, rst = 1'b1;
  logic rd_stb = 1'b0, rd_bit = 1'b0, req_go = 1'b0, retry_en = 1'b0;
  logic [7:0] req_track = '0, req_sector = '0;
  logic nib_vld, busy, done, sum_err, code_err, not_found;
  logic [5:0] nib_val;

  always #2 clk = ~clk;

  sector_seek_reader #(.DATA_LEN(DLEN), .MAX_HDRS(MAXH), .MAX_RETRY(MAXR))
    i_sector_seek_reader (
      .clk(clk), .rst(rst), .rd_stb(rd_stb), .rd_bit(rd_bit), .req_go(req_go),
      .req_track(req_track), .req_sector(req_sector), .retry_en(retry_en),
      .nib_vld(nib_vld), .nib_val(nib_val), .busy(busy), .done(done),
      .sum_err(sum_err), .code_err(code_err), .not_found(not_found));

  int tests = 0, fails = 0, gap_max = 0;
  logic [7:0] enc [64];
  int dat [DLEN];
  int done_cnt = 0;
  logic got_sum = 0, got_code = 0, got_nf = 0, pulse_bad = 0, prev_done = 0;
  logic [5:0] nib_log [$];

  always @(negedge clk) begin
    if (!rst) begin
      if (nib_vld) nib_log.push_back(nib_val);
      if (done) begin
        done_cnt++;
        got_sum = sum_err; got_code = code_err; got_nf = not_found;
      end
      if (done && prev_done) pulse_bad = 1'b1;
      prev_done = done;
    end
  end

  task automatic report();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic bit b_valid(input int c);
    bit adj = 0;
    int zp = 0;
    if (c < 128 || c > 255) return 0;
    for (int i = 0; i < 6; i++) if (c[i] && c[i+1]) adj = 1;
    for (int i = 0; i < 7; i++) if (!c[i] && !c[i+1]) zp++;
    return adj && (zp < 2);
  endfunction

  task automatic sbit(input bit b);
    rd_stb = 1'b1; rd_bit = b;
    @(negedge clk);
    if (gap_max > 0) begin
      int g = $urandom_range(gap_max, 0);
      if (g > 0) begin
        rd_stb = 1'b0;
        repeat (g) @(negedge clk);
      end
    end
  endtask

  task automatic sbyte(input logic [7:0] b, input int zeros);
    for (int i = 7; i >= 0; i--) sbit(b[i]);
    for (int i = 0; i < zeros; i++) sbit(1'b0);
  endtask

  task automatic s44(input logic [7:0] v);
    sbyte((v >> 1) | 8'hAA, 0);
    sbyte(v | 8'hAA, 0);
  endtask

  task automatic sector(input logic [7:0] t, input logic [7:0] s,
                        input bit bad_sum, input int ill_at);
    int x = 0;
    for (int i = 0; i < 4; i++) sbyte(8'hFF, 2);
    sbyte(8'hD5, 0); sbyte(8'hAA, 0); sbyte(8'h96, 0);
    s44(8'h2A); s44(t); s44(s); s44(8'h2A ^ t ^ s);
    sbyte(8'hDE, 0); sbyte(8'hAA, 0); sbyte(8'hEB, 0);
    for (int i = 0; i < 3; i++) sbyte(8'hFF, 1);
    sbyte(8'hD5, 0); sbyte(8'hAA, 0); sbyte(8'hAD, 0);
    for (int i = 0; i < DLEN; i++) begin
      if (i == ill_at) sbyte(8'h95, 0);
      else sbyte(enc[dat[i]], 0);
      x = x ^ dat[i];
    end
    sbyte(enc[bad_sum ? ((x ^ 1) & 63) : x], 0);
    sbyte(8'hDE, 0); sbyte(8'hAA, 0); sbyte(8'hEB, 0); sbyte(8'hFF, 0);
    rd_stb = 1'b0;
  endtask

  task automatic fill_data();
    for (int i = 0; i < DLEN; i++) dat[i] = $urandom_range(63, 0);
  endtask

  task automatic go(input logic [7:0] t, input logic [7:0] s, input bit r);
    done_cnt = 0; nib_log.delete(); pulse_bad = 1'b0;
    req_track = t; req_sector = s; retry_en = r; req_go = 1'b1;
    @(negedge clk);
    req_go = 1'b0;
  endtask

  function automatic int data_miss(input int off);
    int m = 0;
    for (int i = 0; i < DLEN; i++)
      if (off + i >= nib_log.size() || int'(nib_log[off+i]) != dat[i]) m++;
    return m;
  endfunction

  task automatic expect_ok(input string req, input int nibs);
    repeat (10) @(negedge clk);
    chk(done_cnt == 1, {req, " one done"}, done_cnt, 1);
    chk({got_sum, got_code, got_nf} == 3'b000, {req, " no flag"},
        int'({got_sum, got_code, got_nf}), 0);
    chk(nib_log.size() == nibs, {req, " value count"}, nib_log.size(), nibs);
    chk(data_miss(nibs - DLEN) == 0, {req, " values"}, data_miss(nibs - DLEN), 0);
    chk(!pulse_bad, "R11 done single cycle", int'(pulse_bad), 0);
  endtask

  initial begin
    int n = 0;
    void'($urandom(32'h5EC7_0A11));
    repeat (5) @(negedge clk);
    // R10 reset state
    chk({busy, done, sum_err, code_err, not_found, nib_vld} == 6'b0,
        "R10 reset outputs", int'({busy, done, sum_err, code_err, not_found, nib_vld}), 0);
    rst = 1'b0;
    @(negedge clk);

    // R4 code table built from the legality rule
    for (int c = 128; c < 256; c++)
      if (b_valid(c)) begin
        if (n < 64) enc[n] = 8'(c);
        n++;
      end
    chk(n == 64, "R4 legal code count", n, 64);
    chk(enc[0] == 8'h96 && enc[63] == 8'hFF, "R4 table ends",
        int'(enc[0]), 32'h96);

    // R1 R2 R3 R4 R5: directed, back-to-back bits, track miss then sector miss
    gap_max = 0;
    fill_data(); dat[0] = 0; dat[DLEN-1] = 63; dat[1] = 63; dat[2] = 0;
    go(8'd5, 8'd9, 1'b0);
    chk(busy == 1'b1, "R10 busy after start", int'(busy), 1);
    sector(8'd7, 8'd9, 0, -1);
    sector(8'd5, 8'd3, 0, -1);
    sector(8'd5, 8'd9, 0, -1);
    expect_ok("R1 R2 R3 R5 directed", DLEN);

    // R5 R6: random tracks, sectors, data and bit gaps
    for (int it = 0; it < 6; it++) begin
      logic [7:0] t = 8'($urandom_range(255, 0));
      logic [7:0] s0 = 8'($urandom_range(255, 0));
      int tgt = $urandom_range(2, 0);
      gap_max = $urandom_range(3, 0);
      fill_data();
      if (it == 0) begin dat[DLEN-1] = 0; dat[0] = 63; end
      go(t, 8'(s0 + 8'(tgt)), 1'b0);
      for (int k = 0; k < 3; k++) sector(t, 8'(s0 + 8'(k)), 0, -1);
      expect_ok("R6 random sector", DLEN);
    end

    // R6 R9: corrupted checksum, retry off
    gap_max = 0; fill_data();
    go(8'd12, 8'd4, 1'b0);
    sector(8'd12, 8'd4, 1, -1);
    repeat (10) @(negedge clk);
    chk(done_cnt == 1 && got_sum && !got_code && !got_nf, "R6 checksum error",
        int'({got_sum, got_code, got_nf}), 4);
    chk(nib_log.size() == DLEN, "R9 no retry value count", nib_log.size(), DLEN);

    // R7: illegal code in field
    gap_max = 1; fill_data();
    go(8'd12, 8'd4, 1'b0);
    sector(8'd12, 8'd4, 0, 5);
    repeat (10) @(negedge clk);
    chk(done_cnt == 1 && got_code && !got_sum, "R7 illegal code",
        int'({got_sum, got_code, got_nf}), 2);
    chk(nib_log.size() == 5, "R7 values before abort", nib_log.size(), 5);
    chk(code_err == 1'b1, "R11 flag held", int'(code_err), 1);

    // R10: start clears flags; R8: not found after MAXH misses
    go(8'd20, 8'd1, 1'b0);
    chk(code_err == 1'b0 && busy == 1'b1, "R10 start clears flags",
        int'({code_err, busy}), 1);
    for (int k = 0; k < MAXH; k++) sector(8'd20, 8'(k + 2), 0, -1);
    sector(8'd20, 8'd1, 0, -1);
    repeat (10) @(negedge clk);
    chk(done_cnt == 1 && got_nf && !got_sum && !got_code, "R8 not found",
        int'({got_sum, got_code, got_nf}), 1);
    chk(nib_log.size() == 0, "R8 no values", nib_log.size(), 0);

    // R8: match at the last allowed header
    fill_data();
    go(8'd20, 8'd1, 1'b0);
    for (int k = 0; k < MAXH - 1; k++) sector(8'd20, 8'(k + 2), 0, -1);
    sector(8'd20, 8'd1, 0, -1);
    expect_ok("R8 last header match", DLEN);

    // R9: retry hides one failure
    gap_max = 0; fill_data();
    go(8'd33, 8'd15, 1'b1);
    sector(8'd33, 8'd15, 1, -1);
    sector(8'd33, 8'd15, 0, -1);
    expect_ok("R9 retry recovers", 2 * DLEN);

    // R9: retry budget used up
    go(8'd33, 8'd15, 1'b1);
    sector(8'd33, 8'd15, 1, -1);
    sector(8'd33, 8'd15, 1, -1);
    repeat (10) @(negedge clk);
    chk(done_cnt == 1 && got_sum, "R9 retry exhausted", int'(got_sum), 1);
    chk(nib_log.size() == 2 * DLEN, "R9 retry value count", nib_log.size(), 2 * DLEN);

    report();
  end
endmodule